// File: doc/BRIEF.md
# Page-Mode Memory Read Front End

This block is the read side of a 16-bit-wide memory array that can also be read one byte at a time. A host raises a chip select, presents a word address plus a byte-lane bit, and after a modelled access delay the block drives the addressed data. The block also returns a one-cycle `data_valid` pulse. Output drivers are modelled by a separate enable for each byte half. A half whose enable is low reads as zero on `dq_out`, and the pad would be high impedance there.

Accesses that stay inside one 8-word page while chip select stays asserted finish in half the cycles of a full random access. A byte-width mode parks the upper output half and routes either byte of the addressed word onto the lower half. An identify mode replaces array data with a fixed manufacturer or device code. Each code carries odd parity in bit 15.

The read stream has no back-pressure. `data_valid` is a single-cycle strobe with no ready input. The data stays on `dq_out` while chip select and output enable are held and no new access begins. A consumer that misses the strobe can still sample the held word.

Top module: `page_read_frontend`

## Requirements
- R1: After reset, `data_valid`, `dq_oe_lo` and `dq_oe_hi` are 0 and `dq_out` is 0.
- R2: With chip select held, any change of address, byte-lane, byte-mode or identify inputs starts an access. A full access pulses `data_valid` in the cycle after FULL_LAT rising edges following the sampling edge. The bench sees this as `data_valid` high at the (FULL_LAT+1)-th falling edge after the inputs change. Array word at address a = (a*40503 + 4660) mod 65536.
- R3: A page hit completes in FULL_LAT/2 cycles. A page hit is an access with chip select held, identify off now and before, byte mode unchanged, and word address bits above bit 2 unchanged.
- R4: A change of any word-address bit above bit 2 is a full access. The first access after chip select is deasserted and reasserted is also a full access.
- R5: `data_valid` is high for exactly one cycle per completed access.
- R6: Both output enables are 0 whenever `chip_en` or `out_en` is 0, and while an access is in flight. A half whose enable is 0 reads 0 on `dq_out`. Dropping only `out_en` keeps the held data.
- R7: In word mode (`byte_mode`=0), both enables are 1 and `dq_out` equals the full addressed word.
- R8: In byte mode (`byte_mode`=1), `dq_oe_hi` is 0 and `dq_out[15:8]` is 0. `dq_out[7:0]` carries word bits 15:8 when `byte_lane`=1 and word bits 7:0 when `byte_lane`=0.
- R9: In identify mode, address 0 returns manufacturer code 16'h00C2 and address 1 returns device code 16'hBA11. Every code has an odd number of ones, with bit 15 as the parity bit. Identify accesses are always full accesses.
- R10: In identify mode with any word-address bit above bit 0 set, the result is 16'hFFFF.
- R11: An input change while an access is in flight restarts timing from the new change. Only the new address's data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| word_addr | input | ADDR_W | Word address |
| byte_lane | input | 1 | Byte select within the word in byte mode |
| byte_mode | input | 1 | 1 = 8-bit reads, 0 = 16-bit reads |
| ident_mode | input | 1 | 1 = return identifier codes |
| dq_out | output | 16 | Read data, zero on disabled halves |
| dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15:8 |
| data_valid | output | 1 | One-cycle strobe when a read completes |

## Verification
The bench measures latency for accesses that toggle only the low three address bits or the byte-lane bit. A design that misjudged page membership would return these reads at full latency, or return a page miss at half latency. It also changes the address in the middle of an access, where a design that failed to restart would deliver the stale word or finish early. It drops chip select and then re-reads the same address, which catches a page-open flag that survives deselection. Identify reads with a stray high address bit and byte-lane steering in both directions expose wrong codes, even parity, or the upper half left driven.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WAIT = 2'd1,
    ACC_HOLD = 2'd2
  } acc_state_t;

  // Deterministic array contents: (a*40503 + 4660) mod 2^16
  function automatic logic [15:0] array_word(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd40503 + 32'd4660;
    return t[15:0];
  endfunction

  // Append a parity bit in bit 15 so the whole code has odd weight
  function automatic logic [15:0] odd_code(input logic [14:0] v);
    return {~^v, v};
  endfunction

endpackage

// File: rtl/prf_array.sv
module prf_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_word
);
  import prf_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] cells [DEPTH];

  // Contents are loaded while reset is held; there is no write path on the read side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= array_word(32'(i));
    end
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/prf_access_ctrl.sv
module prf_access_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int FULL_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              byte_lane,
  input  logic              byte_mode,
  input  logic              ident_mode,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_lane,
  output logic              sel_bm,
  output logic              sel_id,
  output logic              finish,
  output logic              done,
  output logic              holding
);
  import prf_pkg::*;

  localparam int PAGE_LAT = FULL_LAT / 2;
  localparam int CW       = $clog2(FULL_LAT + 1);
  localparam int PW       = 3;

  acc_state_t    state;
  logic [CW-1:0] cnt;
  logic          open_q;
  logic          changed, start, hit;
  logic [CW-1:0] load_val;

  assign changed = (word_addr != sel_addr) || (byte_lane != sel_lane) ||
                   (byte_mode != sel_bm) || (ident_mode != sel_id);
  assign start   = chip_en && (!open_q || changed);
  assign hit     = open_q && !ident_mode && !sel_id && (byte_mode == sel_bm) &&
                   (word_addr[ADDR_W-1:PW] == sel_addr[ADDR_W-1:PW]);
  assign load_val = hit ? CW'(PAGE_LAT - 1) : CW'(FULL_LAT - 1);
  assign finish  = chip_en && !start && (state == ACC_WAIT) && (cnt == '0);
  assign holding = (state == ACC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ACC_IDLE;
      cnt      <= '0;
      open_q   <= 1'b0;
      done     <= 1'b0;
      sel_addr <= '0;
      sel_lane <= 1'b0;
      sel_bm   <= 1'b0;
      sel_id   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!chip_en) begin
        state  <= ACC_IDLE;
        open_q <= 1'b0;
      end else if (start) begin
        sel_addr <= word_addr;
        sel_lane <= byte_lane;
        sel_bm   <= byte_mode;
        sel_id   <= ident_mode;
        open_q   <= 1'b1;
        cnt      <= load_val;
        state    <= ACC_WAIT;
      end else if (finish) begin
        state <= ACC_HOLD;
        done  <= 1'b1;
      end else if (state == ACC_WAIT) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3: the countdown never exceeds the full-access window
  a_r3_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACC_WAIT) |-> (cnt < CW'(FULL_LAT)));

  // R5: completion strobe lasts one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: a completion is always preceded by a waiting access
  a_r2_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == ACC_WAIT));

  // R11: a fresh input change always re-enters the waiting state
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ACC_WAIT) && !done);

endmodule

// File: rtl/prf_lane_steer.sv
module prf_lane_steer (
  input  logic [15:0] word_in,
  input  logic        byte_mode,
  input  logic        byte_lane,
  output logic [15:0] steered
);
  always_comb begin
    if (!byte_mode)     steered = word_in;
    else if (byte_lane) steered = {8'h00, word_in[15:8]};
    else                steered = {8'h00, word_in[7:0]};
  end
endmodule

// File: rtl/page_read_frontend.sv
module page_read_frontend #(
  parameter int          ADDR_W   = 8,
  parameter int          FULL_LAT = 8,
  parameter logic [14:0] MFR_ID   = 15'h00C2,
  parameter logic [14:0] DEV_ID   = 15'h3A11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              byte_lane,
  input  logic              byte_mode,
  input  logic              ident_mode,
  output logic [15:0]       dq_out,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi,
  output logic              data_valid
);
  import prf_pkg::*;

  localparam logic [15:0] MFR_CODE = odd_code(MFR_ID);
  localparam logic [15:0] DEV_CODE = odd_code(DEV_ID);
  localparam logic [15:0] BAD_ID   = 16'hFFFF;

  logic [ADDR_W-1:0] sel_addr;
  logic              sel_lane, sel_bm, sel_id;
  logic              finish, holding;
  logic [15:0]       arr_word, raw_word, steered, data_q;
  logic              id_ok;
  logic              drive;

  prf_access_ctrl #(.ADDR_W(ADDR_W), .FULL_LAT(FULL_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
    .word_addr(word_addr), .byte_lane(byte_lane),
    .byte_mode(byte_mode), .ident_mode(ident_mode),
    .sel_addr(sel_addr), .sel_lane(sel_lane), .sel_bm(sel_bm), .sel_id(sel_id),
    .finish(finish), .done(data_valid), .holding(holding)
  );

  prf_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(sel_addr), .rd_word(arr_word)
  );

  assign id_ok = (sel_addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (!sel_id)       raw_word = arr_word;
    else if (!id_ok)   raw_word = BAD_ID;
    else if (sel_addr[0]) raw_word = DEV_CODE;
    else               raw_word = MFR_CODE;
  end

  prf_lane_steer u_steer (
    .word_in(raw_word), .byte_mode(sel_bm), .byte_lane(sel_lane), .steered(steered)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (finish) data_q <= steered;
  end

  assign drive    = chip_en && out_en && holding;
  assign dq_oe_lo = drive;
  assign dq_oe_hi = drive && !sel_bm;
  assign dq_out   = {dq_oe_hi ? data_q[15:8] : 8'h00, dq_oe_lo ? data_q[7:0] : 8'h00};

  // R6: no half drives while either select is inactive
  a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_en && out_en) |-> (!dq_oe_lo && !dq_oe_hi));

  // R6: a quiet bus reads as zero
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_lo |-> (dq_out == 16'h0000));

  // R8: upper half parked reads zero in byte mode
  a_r8_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_lo && !dq_oe_hi) |-> (dq_out[15:8] == 8'h00));

  // R9: valid identifier words have odd weight
  a_r9_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && sel_id && id_ok && !sel_bm) |-> (^data_q));

endmodule

// File: tb/page_read_frontend_tb.sv
`timescale 1ns/1ps
module page_read_frontend_tb;
  localparam int AW   = 8;
  localparam int FULL = 8;
  localparam int HALF = FULL / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, out_en = 1'b0;
  logic [AW-1:0] word_addr = '0;
  logic byte_lane = 1'b0, byte_mode = 1'b0, ident_mode = 1'b0;
  logic [15:0] dq_out;
  logic dq_oe_lo, dq_oe_hi, data_valid;

  int checks = 0;
  int errors = 0;

  // model of the page state
  logic [AW-1:0] m_addr = '0;
  logic m_lane = 1'b0, m_bm = 1'b0, m_id = 1'b0, m_open = 1'b0;

  always #2 clk = ~clk;

  page_read_frontend #(.ADDR_W(AW), .FULL_LAT(FULL)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
    .word_addr(word_addr), .byte_lane(byte_lane), .byte_mode(byte_mode),
    .ident_mode(ident_mode), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo),
    .dq_oe_hi(dq_oe_hi), .data_valid(data_valid)
  );

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'd4660;
    return t[15:0];
  endfunction

  function automatic logic [15:0] exp_word(input logic [AW-1:0] a, input logic ln,
                                           input logic bm, input logic id);
    logic [15:0] w;
    if (!id) w = mem_word(a);
    else if (a > 1) w = 16'hFFFF;
    else if (a == 1) w = 16'hBA11;
    else w = 16'h00C2;
    if (!bm) return w;
    return ln ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic int exp_lat(input logic [AW-1:0] a, input logic bm, input logic id);
    if (m_open && !id && !m_id && bm == m_bm && a[AW-1:3] == m_addr[AW-1:3]) return HALF;
    return FULL;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive inputs (called right after a falling edge), wait for the strobe, check result
  task automatic do_access(input logic [AW-1:0] a, input logic ln, input logic bm,
                           input logic id, input string req);
    int lat;
    int k;
    lat = exp_lat(a, bm, id);
    word_addr = a; byte_lane = ln; byte_mode = bm; ident_mode = id;
    m_addr = a; m_lane = ln; m_bm = bm; m_id = id; m_open = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (!data_valid && k < 64)
        chk(!dq_oe_lo && !dq_oe_hi, "R6", {30'd0, dq_oe_hi, dq_oe_lo}, 0);
    end while (!data_valid && k < 64);
    chk(k == lat + 1, req, k, lat + 1);
    chk(dq_out == exp_word(a, ln, bm, id), req, dq_out, exp_word(a, ln, bm, id));
    chk(dq_oe_lo == 1'b1 && dq_oe_hi == !bm, bm ? "R8" : "R7",
        {30'd0, dq_oe_hi, dq_oe_lo}, {30'd0, !bm, 1'b1});
    @(negedge clk);
    chk(!data_valid, "R5", data_valid, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5581));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!data_valid && !dq_oe_lo && !dq_oe_hi && dq_out == 0, "R1",
        {dq_out, 13'd0, data_valid, dq_oe_hi, dq_oe_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!data_valid && dq_out == 0, "R1", dq_out, 0);
    chip_en = 1'b1; out_en = 1'b1;

    // R2 / R7: first access is a full access
    do_access(8'h28, 1'b0, 1'b0, 1'b0, "R2");
    // R3: page hit on low bits
    do_access(8'h2D, 1'b0, 1'b0, 1'b0, "R3");
    // R4: upper bit change forces full latency
    do_access(8'h35, 1'b0, 1'b0, 1'b0, "R4");
    // R8: byte mode, both lanes; second is a page hit via lane bit only
    do_access(8'h35, 1'b1, 1'b1, 1'b0, "R8");
    do_access(8'h35, 1'b0, 1'b1, 1'b0, "R8");
    do_access(8'h31, 1'b1, 1'b1, 1'b0, "R3");

    // R6: out_en low gates the bus but keeps the data
    out_en = 1'b0;
    @(negedge clk);
    chk(!dq_oe_lo && !dq_oe_hi && dq_out == 0, "R6", dq_out, 0);
    out_en = 1'b1;
    @(negedge clk);
    chk(dq_out == exp_word(8'h31, 1'b1, 1'b1, 1'b0) && dq_oe_lo, "R6",
        dq_out, exp_word(8'h31, 1'b1, 1'b1, 1'b0));

    // R4: deselect then same address -> full latency
    chip_en = 1'b0;
    @(negedge clk);
    chk(!dq_oe_lo && !dq_oe_hi, "R6", {dq_oe_hi, dq_oe_lo}, 0);
    m_open = 1'b0;
    chip_en = 1'b1;
    do_access(8'h31, 1'b1, 1'b1, 1'b0, "R4");

    // R9 / R10: identify codes
    do_access(8'h00, 1'b0, 1'b0, 1'b1, "R9");
    chk(^dq_out == 1'b1, "R9", dq_out, 16'h00C2);
    do_access(8'h01, 1'b0, 1'b0, 1'b1, "R9");
    chk(^dq_out == 1'b1, "R9", dq_out, 16'hBA11);
    do_access(8'h05, 1'b0, 1'b0, 1'b1, "R10");
    do_access(8'h01, 1'b1, 1'b1, 1'b1, "R9");
    do_access(8'h06, 1'b0, 1'b0, 1'b0, "R2");

    // R11: change mid-access, new page
    word_addr = 8'hA3; m_addr = 8'hA3; m_lane = 1'b0; m_bm = 1'b0; m_id = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!data_valid, "R11", data_valid, 0);
    do_access(8'h5A, 1'b0, 1'b0, 1'b0, "R11");

    // random mix, half of it inside the current page
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      logic ln, bm;
      a  = ($urandom % 2 == 0) ? {m_addr[AW-1:3], 3'($urandom)} : AW'($urandom);
      bm = ($urandom % 6 == 0) ? !m_bm : m_bm;
      ln = 1'($urandom);
      if (a == m_addr && ln == m_lane && bm == m_bm) a[0] = !a[0];
      do_access(a, ln, bm, 1'b0, exp_lat(a, bm, 1'b0) == HALF ? "R3" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule